// File: doc/BRIEF.md
# 100 Mb/s Transmit Code-Group Framer

This block turns the nibble-wide transmit stream coming from a MAC into a stream of 5-bit code groups for a 100 Mb/s twisted-pair link, one code group per 25 MHz clock. When no frame is in progress it sends idle code groups. When a frame starts, the first two nibbles (the leading preamble byte) are replaced by the start delimiter pair. Each later nibble is mapped through the 4B/5B table. When the enable input drops, the end delimiter pair is appended.

Every code group is then whitened by an 11-bit stream-cipher scrambler before it leaves the block. A line coder downstream consumes the result. The framer enforces at least one idle code group between frames: nibbles offered before the block is back in its idle state are dropped.

Top module: `tx_symbol_framer`

## Requirements
- R1: With `tx_en` low and no frame in progress, the unscrambled code group is idle, 11111; `tx_err` has no effect outside a frame.
- R2: The cycle that starts a frame yields J (11000) and the next cycle yields K (10001), whatever `tx_data` and `tx_err` hold in those two cycles.
- R3: From the third frame cycle on, while `tx_en` is high and `tx_err` is low, nibble values 0..F map to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R4: A data cycle with `tx_err` high yields H (00100) instead of the nibble's code.
- R5: The first cycle of a frame with `tx_en` low yields T (01101), and the next cycle yields R (00111).
- R6: The cycle after R always yields idle, and `tx_en` is ignored during R and that idle cycle. A new frame's J is emitted only from the idle state.
- R7: The scrambler implements x^11 + x^9 + 1 with an 11-bit state s, seeded to all ones at reset. For each code bit, from bit 4 down to bit 0: f = s[10] ^ s[8], the output bit is the code bit ^ f, and s becomes {s[9:0], f}. This gives five steps per clock after reset.
- R8: The inputs sampled at clock edge k determine `code_out` directly after edge k (one register of latency).
- R9: During reset `code_out` is 00000. The scrambler state is never all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Frame enable from the MAC |
| tx_data | input | 4 | Transmit nibble |
| tx_err | input | 1 | Transmit error, forces a halt code group |
| code_out | output | 5 | Scrambled code group |

## Verification
On every cycle, the assertions check the fixed delimiter orderings: J is followed by K, T by R, and R by idle. They also check that the scrambler state never reaches zero. The bench scenarios must show the rest. These are the full 16-entry nibble mapping, halt substitution, preamble override, and the dropping of nibbles that arrive before the gap ends. They also cover the exact scrambled bit sequence and its one-cycle latency, which the bench predicts with its own scrambler model.

// File: rtl/tx_framer_pkg.sv
package tx_framer_pkg;
    localparam int NIB_W  = 4;
    localparam int CODE_W = 5;

    localparam logic [CODE_W-1:0] CG_IDLE = 5'b11111;
    localparam logic [CODE_W-1:0] CG_J    = 5'b11000;
    localparam logic [CODE_W-1:0] CG_K    = 5'b10001;
    localparam logic [CODE_W-1:0] CG_T    = 5'b01101;
    localparam logic [CODE_W-1:0] CG_R    = 5'b00111;
    localparam logic [CODE_W-1:0] CG_H    = 5'b00100;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_SECOND,
        FR_DATA,
        FR_TAIL,
        FR_GAP
    } frame_state_e;

    function automatic logic [CODE_W-1:0] map_nibble(input logic [NIB_W-1:0] n);
        logic [CODE_W-1:0] c;
        case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/frame_sequencer.sv
module frame_sequencer
    import tx_framer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic [NIB_W-1:0]  tx_data,
    input  logic              tx_err,
    output logic [CODE_W-1:0] raw_code
);
    typedef struct packed {
        frame_state_e st;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        raw_code = CG_IDLE;
        case (seq_q.st)
            FR_IDLE: begin
                if (tx_en) begin
                    raw_code = CG_J;
                    seq_d.st = FR_SECOND;
                end
            end
            FR_SECOND: begin
                raw_code = CG_K;
                seq_d.st = FR_DATA;
            end
            FR_DATA: begin
                if (!tx_en) begin
                    raw_code = CG_T;
                    seq_d.st = FR_TAIL;
                end else if (tx_err) begin
                    raw_code = CG_H;
                end else begin
                    raw_code = map_nibble(tx_data);
                end
            end
            FR_TAIL: begin
                raw_code = CG_R;
                seq_d.st = FR_GAP;
            end
            default: begin
                raw_code = CG_IDLE;
                seq_d.st = FR_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{st: FR_IDLE};
        else        seq_q <= seq_d;
    end

    // R2
    start_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_code == CG_J |=> raw_code == CG_K);
    // R5
    end_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_code == CG_T |=> raw_code == CG_R);
    // R6
    gap_after_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_code == CG_R |=> raw_code == CG_IDLE);
endmodule

// File: rtl/stream_scrambler.sv
module stream_scrambler #(
    parameter int CODE_W  = 5,
    parameter int LFSR_W  = 11,
    parameter int TAP_EXP = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_out
);
    localparam int HI = LFSR_W - 1;
    localparam int LO = TAP_EXP - 1;

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic [CODE_W-1:0] outc;
    } scr_t;

    scr_t scr_d, scr_q;

    always_comb begin
        logic [LFSR_W-1:0] s;
        logic              f;
        s     = scr_q.lfsr;
        scr_d = scr_q;
        for (int i = CODE_W - 1; i >= 0; i--) begin
            f             = s[HI] ^ s[LO];
            scr_d.outc[i] = code_in[i] ^ f;
            s             = {s[LFSR_W-2:0], f};
        end
        scr_d.lfsr = s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) scr_q <= '{lfsr: '1, outc: '0};
        else        scr_q <= scr_d;
    end

    assign code_out = scr_q.outc;

    // R9
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scr_q.lfsr != '0);
endmodule

// File: rtl/tx_symbol_framer.sv
module tx_symbol_framer
    import tx_framer_pkg::*;
#(
    parameter int LFSR_W  = 11,
    parameter int TAP_EXP = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic [NIB_W-1:0]  tx_data,
    input  logic              tx_err,
    output logic [CODE_W-1:0] code_out
);
    logic [CODE_W-1:0] raw_code;

    frame_sequencer seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .tx_data  (tx_data),
        .tx_err   (tx_err),
        .raw_code (raw_code)
    );

    stream_scrambler #(
        .CODE_W  (CODE_W),
        .LFSR_W  (LFSR_W),
        .TAP_EXP (TAP_EXP)
    ) scr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_in  (raw_code),
        .code_out (code_out)
    );
endmodule

// File: tb/tx_symbol_framer_tb.sv
module tx_symbol_framer_tb_top;
    localparam time CLK_PERIOD = 40ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic [3:0] tx_data = 4'h0;
    logic       tx_err = 1'b0;
    logic [4:0] code_out;

    int checks = 0;
    int errors = 0;

    logic [4:0] q_raw[$];
    string      q_tag[$];
    logic [10:0] model_s = 11'h7FF;

    tx_symbol_framer dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
        .tx_data(tx_data), .tx_err(tx_err), .code_out(code_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Unscrambled code groups taken from R1..R5
    function automatic logic [4:0] nib_code(input logic [3:0] n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    // Drives one cycle at the falling edge and queues its expected code group
    task automatic step(input logic en, input logic [3:0] d, input logic er,
                        input logic [4:0] exp_raw, input string tag);
        tx_en = en; tx_data = d; tx_err = er;
        q_raw.push_back(exp_raw);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    // Monitor: applies the R7 scrambler model; R8 latency of one edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && q_raw.size() > 0) begin
                logic [4:0] raw, exp;
                string tag;
                logic f;
                raw = q_raw.pop_front();
                tag = q_tag.pop_front();
                for (int i = 4; i >= 0; i--) begin
                    f = model_s[10] ^ model_s[8];
                    exp[i] = raw[i] ^ f;
                    model_s = {model_s[9:0], f};
                end
                checks++;
                if (code_out !== exp) begin
                    errors++;
                    $display("FAIL %s R7 R8 raw=%b: got %b exp %b", tag, raw, code_out, exp);
                end
            end
        end
    end

    task automatic send_frame(input int n, input logic [3:0] start, input int err_pos);
        for (int i = 0; i < n; i++) begin
            logic [3:0] d;
            d = start + 4'(i);
            if (i == 0)            step(1'b1, d, err_pos == 0, 5'b11000, "R2 J");
            else if (i == 1)       step(1'b1, d, err_pos == 1, 5'b10001, "R2 K");
            else if (i == err_pos) step(1'b1, d, 1'b1, 5'b00100, "R4 halt");
            else                   step(1'b1, d, 1'b0, nib_code(d), "R3 data");
        end
        step(1'b0, 4'h0, 1'b0, 5'b01101, "R5 T");
        step(1'b0, 4'h0, 1'b0, 5'b00111, "R5 R");
        step(1'b0, 4'h0, 1'b0, 5'b11111, "R6 gap");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (code_out !== 5'b00000) begin
            errors++;
            $display("FAIL R9 reset output: got %b exp 00000", code_out);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) step(1'b0, 4'(i), 1'b0, 5'b11111, "R1 idle");
        step(1'b0, 4'h5, 1'b1, 5'b11111, "R1 err outside frame");
        send_frame(18, 4'h0, -1);
        step(1'b0, 4'h0, 1'b0, 5'b11111, "R1 idle");
        send_frame(10, 4'h9, 5);
        send_frame(6, 4'h3, 0);
        send_frame(2, 4'hA, -1);
        // Back-to-back attempt: tx_en high during R and gap is ignored
        send_frame(4, 4'h7, -1);
        step(1'b1, 4'h1, 1'b0, 5'b11000, "R6 J only from idle");
        step(1'b1, 4'h2, 1'b0, 5'b10001, "R2 K");
        step(1'b1, 4'hF, 1'b0, nib_code(4'hF), "R3 data");
        step(1'b0, 4'h0, 1'b0, 5'b01101, "R5 T");
        step(1'b1, 4'h4, 1'b0, 5'b00111, "R6 R ignores tx_en");
        step(1'b1, 4'h4, 1'b0, 5'b11111, "R6 gap ignores tx_en");
        step(1'b1, 4'h6, 1'b0, 5'b11000, "R6 J after gap");
        step(1'b1, 4'h6, 1'b0, 5'b10001, "R2 K");
        step(1'b0, 4'h0, 1'b0, 5'b01101, "R5 T");
        step(1'b0, 4'h0, 1'b0, 5'b00111, "R5 R");
        for (int i = 0; i < 40; i++) step(1'b0, 4'h0, 1'b0, 5'b11111, "R1 R7 idle stream");
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule